// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block is the logic core of a small programmable logic device with ten output cells. Twelve dedicated inputs and ten feedback signals (one per output cell) each enter the array in true and in inverted form, giving 44 columns. Every row of the array is a product term: an AND over the columns that stay connected in that row. A fixed OR plane then sums an unequal, hard-wired group of rows into each of the ten outputs. Further rows supply an asynchronous-reset term, a synchronous-preset term and one output-enable term per output cell. All of these go to the output cells, which are outside this block.

The connection pattern sits in an internal store of 132 rows by 44 bits. A row-wide configuration port writes one row per clock and reads the addressed row back combinationally. A sticky lock bit hides the stored pattern from readback: while it is set, every row reads back as fully programmed. Evaluation is purely combinational from the inputs and the stored pattern, so a change on an input shows at the outputs in the same cycle. A stored bit of 1 means the connection is removed, and 0 means it is kept. After reset every bit is 0, so every cell pair is in its inactive state.

Top module: `sop_array`

## Requirements
- R1: For signal index s, with inputs at s = 0..11 and feedback at s = 12..21, row bit 2s is the true-form cell and bit 2s+1 is the inverted-form cell. The pair value {bit 2s+1, bit 2s} selects the pair's effect on the term. 2'b00 (both kept, inactive) forces the term LOW. 2'b10 needs the signal to be 1. 2'b01 needs the signal to be 0. 2'b11 has no effect.
- R2: A row whose 44 bits are all 1 evaluates HIGH for every input value.
- R3: Row 0 drives `rst_term_o` and the last row (131) drives `pre_term_o`. The rows of output k start with its enable row, followed directly by its sum rows. Output 0's enable row is row 1.
- R4: Output k sums 8, 10, 12, 14, 16, 16, 14, 12, 10, 8 rows for k = 0..9. `sum_o[k]` is the OR of those rows.
- R5: `oe_o[k]` equals the value of output k's enable row.
- R6: Reset clears every stored bit to 0. With the array erased, every row evaluates LOW, so `rst_term_o`, `pre_term_o`, all of `oe_o` and all of `sum_o` are 0 for any input.
- R7: A write (`cfg_we_i` high) to an address below 132 stores `cfg_wdata_i` at the next rising clock edge. `cfg_rdata_o` shows the addressed row combinationally.
- R8: A write to an address of 132 or above changes nothing, and a read of such an address returns zero, even while locked.
- R9: A `lock_set_i` pulse sets the lock, which stays set until reset. While locked, every address below 132 reads back as all ones. Array evaluation and writes are unaffected by the lock.
- R10: The outputs follow the inputs and feedback combinationally, within the same cycle and with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset; erases the array and clears the lock |
| in_i | input | 12 | Dedicated input signals |
| fb_i | input | 10 | Feedback signals from the output cells |
| cfg_we_i | input | 1 | Row write strobe |
| cfg_addr_i | input | 8 | Row address for writing and reading back |
| cfg_wdata_i | input | 44 | Row data to store |
| lock_set_i | input | 1 | Sets the sticky readback lock |
| cfg_rdata_o | output | 44 | Readback of the addressed row |
| sum_o | output | 10 | Sum-of-products result per output |
| oe_o | output | 10 | Output-enable term per output |
| rst_term_o | output | 1 | Global asynchronous-reset term |
| pre_term_o | output | 1 | Global synchronous-preset term |

## Verification
A lock request and a row write can land on the same clock edge. The write must still be stored, and the lock must take hold at once. The bench drives `lock_set_i` and a write to one row in the same cycle. It then judges the result two ways: the outputs must follow the newly written row, while readback of that row and of the others returns all ones. A later write made under the lock must still change the outputs. Reset must clear the lock and the stored pattern together.

// File: rtl/sop_pkg.sv
package sop_pkg;

   // number of summed rows for output k: rises by STEP toward the middle
   function automatic int sum_rows(input int k, input int n_out,
                                   input int base, input int step);
      int d;
      d = (k < n_out - 1 - k) ? k : n_out - 1 - k;
      return base + step * d;
   endfunction

   // row index of the enable row of output k (row 0 is the reset term)
   function automatic int enable_row(input int k, input int n_out,
                                     input int base, input int step);
      int r;
      r = 1;
      for (int j = 0; j < k; j++) r += 1 + sum_rows(j, n_out, base, step);
      return r;
   endfunction

   // total rows: reset, per-output groups, preset
   function automatic int total_rows(input int n_out, input int base,
                                     input int step);
      return enable_row(n_out, n_out, base, step) + 1;
   endfunction

endpackage

// File: rtl/sop_cfg_store.sv
module sop_cfg_store #(
   parameter int ROWS   = 132,
   parameter int COLS   = 44,
   parameter int ADDR_W = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we_i,
   input  logic [ADDR_W-1:0]          addr_i,
   input  logic [COLS-1:0]            wdata_i,
   input  logic                       lock_set_i,
   output logic [COLS-1:0]            rdata_o,
   output logic [ROWS-1:0][COLS-1:0]  cfg_o
);
   localparam int IDX_W = (ROWS > 1) ? $clog2(ROWS) : 1;
   localparam logic [ADDR_W:0] ROWS_L = (ADDR_W + 1)'(ROWS);

   generate
      if (IDX_W > ADDR_W) begin : g_bad_addr
         $error("sop_cfg_store: address too narrow for row count");
      end
   endgenerate

   logic [ROWS-1:0][COLS-1:0] cfg_q;
   logic                      lock_q;
   logic                      hit;
   logic [IDX_W-1:0]          idx;

   assign hit = ({1'b0, addr_i} < ROWS_L);
   assign idx = addr_i[IDX_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         lock_q <= 1'b0;
      end else begin
         if (we_i && hit) cfg_q[idx] <= wdata_i;
         if (lock_set_i)  lock_q     <= 1'b1;
      end
   end

   always_comb begin
      rdata_o = '0;
      if (hit) rdata_o = lock_q ? '1 : cfg_q[idx];
   end

   assign cfg_o = cfg_q;

   // R7: an unlocked read of the row written on the last edge returns its data
   assert_readback_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(we_i) && ({1'b0, $past(addr_i)} < ROWS_L) &&
       (addr_i == $past(addr_i)) && !lock_q) |-> (rdata_o == $past(wdata_i)));

   // R9: the lock, once set, stays set until reset
   assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> lock_q);

   // R8: a write beyond the array leaves every stored row untouched
   assert_oob_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && !hit) |=> $stable(cfg_o));

endmodule

// File: rtl/sop_product_term.sv
module sop_product_term #(
   parameter int NSIG = 22
) (
   input  logic [2*NSIG-1:0] cells_i,
   input  logic [NSIG-1:0]   sig_i,
   output logic              term_o
);
   logic [2*NSIG-1:0] lit;
   logic [NSIG-1:0]   dead;

   generate
      for (genvar s = 0; s < NSIG; s++) begin : g_col
         assign lit[2*s]     = sig_i[s];
         assign lit[2*s + 1] = ~sig_i[s];
         assign dead[s]      = ~cells_i[2*s] & ~cells_i[2*s + 1];
      end
   endgenerate

   // a kept connection passes its literal, a removed one reads as 1
   assign term_o = &(cells_i | lit);

   always_comb begin
      if (|dead) begin
         // R1: an inactive pair forces the term LOW
         assert_inactive_pair_low_R1: assert (term_o == 1'b0)
            else $error("inactive pair did not force term low");
      end
      if (&cells_i) begin
         // R2: a fully opened row is HIGH
         assert_open_row_high_R2: assert (term_o == 1'b1)
            else $error("fully opened row not high");
      end
   end

endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane #(
   parameter int ROWS       = 132,
   parameter int NUM_OUT    = 10,
   parameter int BASE_TERMS = 8,
   parameter int STEP_TERMS = 2
) (
   input  logic [ROWS-1:0]    terms_i,
   output logic [NUM_OUT-1:0] sum_o,
   output logic [NUM_OUT-1:0] oe_o,
   output logic               rst_term_o,
   output logic               pre_term_o
);
   generate
      if (sop_pkg::total_rows(NUM_OUT, BASE_TERMS, STEP_TERMS) != ROWS) begin : g_bad_rows
         $error("sop_or_plane: row count does not match output grouping");
      end
      for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
         localparam int EN_ROW = sop_pkg::enable_row(k, NUM_OUT, BASE_TERMS, STEP_TERMS);
         localparam int CNT    = sop_pkg::sum_rows(k, NUM_OUT, BASE_TERMS, STEP_TERMS);
         assign oe_o[k]  = terms_i[EN_ROW];
         assign sum_o[k] = |terms_i[EN_ROW + 1 +: CNT];
      end
   endgenerate

   assign rst_term_o = terms_i[0];
   assign pre_term_o = terms_i[ROWS-1];

endmodule

// File: rtl/sop_array.sv
module sop_array #(
   parameter int NUM_IN     = 12,
   parameter int NUM_OUT    = 10,
   parameter int BASE_TERMS = 8,
   parameter int STEP_TERMS = 2,
   parameter int ADDR_W     = 8,
   localparam int NSIG      = NUM_IN + NUM_OUT,
   localparam int COLS      = 2 * NSIG
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IN-1:0]  in_i,
   input  logic [NUM_OUT-1:0] fb_i,
   input  logic               cfg_we_i,
   input  logic [ADDR_W-1:0]  cfg_addr_i,
   input  logic [COLS-1:0]    cfg_wdata_i,
   input  logic               lock_set_i,
   output logic [COLS-1:0]    cfg_rdata_o,
   output logic [NUM_OUT-1:0] sum_o,
   output logic [NUM_OUT-1:0] oe_o,
   output logic               rst_term_o,
   output logic               pre_term_o
);
   localparam int ROWS = sop_pkg::total_rows(NUM_OUT, BASE_TERMS, STEP_TERMS);

   generate
      if (NUM_IN < 1 || NUM_OUT < 1 || BASE_TERMS < 1 || STEP_TERMS < 0) begin : g_bad_param
         $error("sop_array: illegal size parameter");
      end
      if (ROWS > (1 << ADDR_W)) begin : g_bad_addr
         $error("sop_array: address width cannot reach every row");
      end
   endgenerate

   logic [ROWS-1:0][COLS-1:0] cfg;
   logic [ROWS-1:0]           terms;
   logic [NSIG-1:0]           sig;

   assign sig = {fb_i, in_i};

   sop_cfg_store #(.ROWS(ROWS), .COLS(COLS), .ADDR_W(ADDR_W)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .we_i       (cfg_we_i),
      .addr_i     (cfg_addr_i),
      .wdata_i    (cfg_wdata_i),
      .lock_set_i (lock_set_i),
      .rdata_o    (cfg_rdata_o),
      .cfg_o      (cfg)
   );

   generate
      for (genvar r = 0; r < ROWS; r++) begin : g_row
         sop_product_term #(.NSIG(NSIG)) u_term (
            .cells_i (cfg[r]),
            .sig_i   (sig),
            .term_o  (terms[r])
         );
      end
   endgenerate

   sop_or_plane #(
      .ROWS(ROWS), .NUM_OUT(NUM_OUT),
      .BASE_TERMS(BASE_TERMS), .STEP_TERMS(STEP_TERMS)
   ) u_or (
      .terms_i    (terms),
      .sum_o      (sum_o),
      .oe_o       (oe_o),
      .rst_term_o (rst_term_o),
      .pre_term_o (pre_term_o)
   );

endmodule

// File: tb/tb_sop_array.sv
module tb_sop_array;
   localparam int PERIOD = 10;
   localparam int NI = 12, NO = 10, NS = 22, NC = 44, NR = 132, AW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NI-1:0] in_v = '0;
   logic [NO-1:0] fb_v = '0;
   logic          we = 1'b0, lock_set = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [NC-1:0] wdata = '0;
   logic [NC-1:0] rdata;
   logic [NO-1:0] sum_v, oe_v;
   logic          ar_v, sp_v;

   int n_chk = 0, n_bad = 0;
   logic [NC-1:0] model [NR];

   always #(PERIOD/2) clk = ~clk;

   sop_array dut (
      .clk(clk), .rst_n(rst_n), .in_i(in_v), .fb_i(fb_v),
      .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
      .lock_set_i(lock_set), .cfg_rdata_o(rdata),
      .sum_o(sum_v), .oe_o(oe_v), .rst_term_o(ar_v), .pre_term_o(sp_v)
   );

   function automatic int cnt_of(int k);
      return (k < 5) ? 8 + 2 * k : 8 + 2 * (9 - k);
   endfunction

   function automatic int oe_of(int k);
      int r = 1;
      for (int j = 0; j < k; j++) r = r + 1 + cnt_of(j);
      return r;
   endfunction

   function automatic logic ev(int r);
      for (int s = 0; s < NS; s++) begin
         logic v;
         logic [1:0] pc;
         v  = (s < NI) ? in_v[s] : fb_v[s - NI];
         pc = {model[r][2*s+1], model[r][2*s]};
         if (pc == 2'b00) return 1'b0;
         if (pc == 2'b10 && !v) return 1'b0;
         if (pc == 2'b01 && v) return 1'b0;
      end
      return 1'b1;
   endfunction

   function automatic logic [21:0] expect_out();
      logic [NO-1:0] s, e;
      for (int k = 0; k < NO; k++) begin
         e[k] = ev(oe_of(k));
         s[k] = 1'b0;
         for (int j = 1; j <= cnt_of(k); j++) s[k] = s[k] | ev(oe_of(k) + j);
      end
      return {ev(0), ev(NR - 1), e, s};
   endfunction

   function automatic logic [NC-1:0] rand_row();
      logic [NC-1:0] d;
      for (int s = 0; s < NS; s++) begin
         int c = $urandom % 16;
         d[2*s+:2] = (c == 0) ? 2'b00 : (c == 1) ? 2'b10 : (c == 2) ? 2'b01 : 2'b11;
      end
      return d;
   endfunction

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_out(string req);
      #1;
      chk(req, {42'd0, ar_v, sp_v, oe_v, sum_v}, {42'd0, expect_out()});
   endtask

   task automatic wr(int a, logic [NC-1:0] d);
      @(negedge clk);
      we = 1'b1; addr = AW'(a); wdata = d;
      @(negedge clk);
      we = 1'b0;
      if (a < NR) model[a] = d;
   endtask

   task automatic rd(int a, logic [NC-1:0] exp, string req);
      @(negedge clk);
      addr = AW'(a);
      #1;
      chk(req, {20'd0, rdata}, {20'd0, exp});
   endtask

   task automatic rand_inputs();
      in_v = NI'($urandom);
      fb_v = NO'($urandom);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
   endtask

   initial begin
      #(PERIOD * 190000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
   end

   initial begin
      for (int r = 0; r < NR; r++) model[r] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R6: erased array, outputs low for varied inputs, rows read zero
      chk_out("R6 erased outputs");
      for (int i = 0; i < 8; i++) begin
         @(negedge clk); rand_inputs();
         chk_out("R6 erased outputs under inputs");
      end
      for (int r = 0; r < NR; r += 13) rd(r, '0, "R6 erased readback");

      // R1: every pair code on every signal, both signal values
      for (int s = 0; s < NS; s++) begin
         for (int c = 0; c < 4; c++) begin
            logic [NC-1:0] d = '1;
            d[2*s]   = c[0];
            d[2*s+1] = c[1];
            wr(0, d);
            for (int v = 0; v < 2; v++) begin
               logic e;
               rand_inputs();
               if (s < NI) in_v[s] = v[0]; else fb_v[s - NI] = v[0];
               e = (c == 0) ? 1'b0 : (c == 2) ? v[0] : (c == 1) ? ~v[0] : 1'b1;
               #1;
               chk("R1 pair code", {63'd0, ar_v}, {63'd0, e});
            end
         end
      end

      // R2: fully opened row is high for any input
      wr(0, '1);
      for (int i = 0; i < 6; i++) begin
         rand_inputs();
         #1;
         chk("R2 open row high", {63'd0, ar_v}, 64'd1);
      end
      wr(0, '0);

      // R3 R4 R5 R7: one opened row at a time walks the whole row map
      for (int r = 0; r < NR; r++) begin
         wr(r, '1);
         rand_inputs();
         chk_out("R3 R4 R5 row map");
         if (r % 11 == 0) rd(r, '1, "R7 readback of written row");
         wr(r, '0);
      end

      // R10 R4 R5: random array, inputs change between clock edges
      for (int r = 0; r < NR; r++) wr(r, rand_row());
      for (int r = 0; r < NR; r += 17) rd(r, model[r], "R7 random readback");
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         rand_inputs();
         chk_out("R10 R4 R5 random evaluation");
         #(PERIOD/4);
         rand_inputs();
         chk_out("R10 mid-cycle input change");
      end

      // R8: writes beyond the array ignored, reads return zero
      wr(200, '1);
      wr(NR, '1);
      rd(200, '0, "R8 unused address reads zero");
      rd(NR, '0, "R8 first unused address reads zero");
      chk_out("R8 outputs unchanged after unused write");
      for (int r = 0; r < NR; r += 29) rd(r, model[r], "R8 rows intact");

      // R9: lock and write on the same edge
      begin
         logic [NC-1:0] x = rand_row();
         @(negedge clk);
         lock_set = 1'b1; we = 1'b1; addr = AW'(7); wdata = x;
         @(negedge clk);
         lock_set = 1'b0; we = 1'b0;
         model[7] = x;
      end
      rd(7, '1, "R9 locked readback of written row");
      rd(0, '1, "R9 locked readback");
      rd(NR - 1, '1, "R9 locked readback last row");
      rd(255, '0, "R9 R8 locked unused address");
      for (int i = 0; i < 10; i++) begin
         @(negedge clk); rand_inputs();
         chk_out("R9 evaluation under lock");
      end
      wr(oe_of(3), '1);
      wr(oe_of(3) + 1, '1);
      chk_out("R9 write under lock takes effect");
      rd(oe_of(3), '1, "R9 lock persists");

      // R6 R9: reset erases array and clears lock
      @(negedge clk);
      rst_n = 1'b0;
      for (int r = 0; r < NR; r++) model[r] = '0;
      @(negedge clk);
      rst_n = 1'b1;
      rd(7, '0, "R6 R9 reset clears lock and array");
      chk_out("R6 outputs after second reset");

      summary();
      $finish;
   end

endmodule